// File: doc/BRIEF.md
# HDR Path Mode Controller

This block turns a requested HDR conversion mode into the enable and select signals for a two-path display overlay. One path is an HDR tone-mapping path. The other converts SDR layers to HDR. Ten conversion modes are defined. For each mode the controller decides three things:

- whether the HDR path takes the primary layer;
- whether the result leaves as HDR or is tone-mapped down to SDR;
- whether the SDR-to-HDR path must run for the other layers.

When the mode keeps an HDR output, the SDR-to-HDR path is switched on by itself as soon as any active layer carries an SDR transfer function.

Configuration software presents a mode code, the transfer function of the primary layer, per-layer active and transfer-function bits, and a destination-gamut bit. It then pulses an update strobe. A separate "no metadata" flag switches every path off.

All results are registered and appear one clock after the strobe. A request is rejected when its code is out of range, or when an HDR-source mode is paired with a primary layer that is not HDR. A rejected request raises an error flag and leaves the previous configuration untouched.

Top module: `hdr_path_ctrl`

## Requirements
- R1: While the synchronous active-low reset is asserted, every output is 0 (all five enables, the error flag and the whole control word) from the first clock edge on.
- R2: An update with a mode code above 9 sets the error flag. The five enables and the control word keep their previous values.
- R3: An update with a mode code from 0 to 7 is rejected when the primary transfer-function code is not PQ (2) or HLG (3). Codes 0 and 1 both mean SDR. The error flag is set, and the enables and control word hold.
- R4: An accepted mode from 0 to 7 sets hdr_en and hdr_in. An accepted mode 8 or 9 clears hdr_en and hdr_in and sets both sdr2hdr_en and hdr_out. Modes 8 and 9 accept any primary transfer function.
- R5: Accepted modes 1, 3, 5 and 7 set hdr2sdr_en and clear hdr_out and sdr2hdr_en, whatever the layers carry.
- R6: Accepted modes 0, 2, 4 and 6 clear hdr2sdr_en and set hdr_out. They set sdr2hdr_en only if some layer with its active bit set has a transfer-function code of 0 or 1. Layer i uses bits [2i+1:2i] of the packed layer transfer-function input. Inactive layers are ignored.
- R7: Control word bit 0 (tone-map enable) is 1 for accepted modes 0 to 5 and 7. It is 0 for mode 6 and for modes 8 and 9.
- R8: Control word bit 2 (bypass) is 1 only for mode 6. Bits 5:3 hold the path mode, which is the mode code for modes 0 to 6, 1 for mode 7, and 0 for modes 8 and 9. Bits 1 and 7 are always 0.
- R9: Control word bit 6 copies the destination-gamut input present at an accepted update.
- R10: When the no-metadata flag is high at a clock edge, all five enables, the error flag and the control word become 0. This takes priority over the update strobe.
- R11: With the strobe low and the no-metadata flag low, no output changes, whatever the other inputs do.
- R12: An accepted update replaces the whole previous configuration and clears the error flag. Outputs change at the first clock edge at which the strobe is sampled high, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | Update strobe: evaluate the presented request |
| meta_null | input | 1 | No metadata: switch all paths off |
| mode_req | input | MODE_W | Requested conversion mode code |
| prim_tf | input | 2 | Transfer-function code of the primary layer (0/1 SDR, 2 PQ, 3 HLG) |
| layer_active | input | NUM_LAYERS | Per-layer active bits |
| layer_tf | input | 2*NUM_LAYERS | Packed per-layer transfer-function codes |
| dst_gamut | input | 1 | Destination-gamut select copied into the control word |
| hdr_en | output | 1 | HDR tone-mapping path enabled |
| hdr_in | output | 1 | Primary layer routed into the HDR path |
| hdr_out | output | 1 | Overlay output stays HDR |
| sdr2hdr_en | output | 1 | SDR-to-HDR path enabled |
| hdr2sdr_en | output | 1 | HDR path maps down to SDR |
| cfg_err | output | 1 | Last request rejected |
| ctrl_word | output | CW_W | Packed path control word |

## Verification
A wrong held or cleared enable is visible at the ports in the cycle right after the strobe edge. It also stays visible, because nothing but a new accepted update, the no-metadata flag or reset can change it. A decode fault shows up as a wrong enable pattern or control-word field for particular mode codes, so every code is walked with layer mixes that do and do not contain active SDR layers. A rejection path that corrupted state would be exposed by comparing outputs before and after the bad request. A premature update would be exposed by sampling just before the capturing edge.

// File: rtl/hdr_path_pkg.sv
package hdr_path_pkg;

   localparam int TF_W = 2;

   typedef enum logic [3:0] {
      M_PQ_DYN       = 4'd0,
      M_PQ_SDR_DYN   = 4'd1,
      M_HLG_PQ_DYN   = 4'd2,
      M_HLG_SDR_DYN  = 4'd3,
      M_HLG_PQ_STAT  = 4'd4,
      M_HLG_SDR_STAT = 4'd5,
      M_BYPASS       = 4'd6,
      M_HDR10_SDR    = 4'd7,
      M_SDR_PQ       = 4'd8,
      M_SDR_HLG      = 4'd9
   } conv_mode_e;

   localparam logic [TF_W-1:0] TF_PQ  = 2'd2;
   localparam logic [TF_W-1:0] TF_HLG = 2'd3;

   // control word field positions
   localparam int CW_TONE  = 0;
   localparam int CW_BYP   = 2;
   localparam int CW_PATH  = 3;
   localparam int CW_GAMUT = 6;

   typedef struct packed {
      logic hdr_en;
      logic hdr_in;
      logic hdr_out;
      logic sdr2hdr_en;
      logic hdr2sdr_en;
   } path_en_t;

   function automatic logic tf_is_hdr(input logic [TF_W-1:0] tf);
      return (tf == TF_PQ) || (tf == TF_HLG);
   endfunction

endpackage

// File: rtl/hdr_layer_scan.sv
module hdr_layer_scan
   import hdr_path_pkg::*;
#(
   parameter int NUM_LAYERS = 4
) (
   input  logic [NUM_LAYERS-1:0]      layer_active,
   input  logic [TF_W*NUM_LAYERS-1:0] layer_tf,
   output logic                       any_sdr
);

   logic [NUM_LAYERS-1:0] sdr_hit;

   for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_layer
      assign sdr_hit[i] = layer_active[i] && !tf_is_hdr(layer_tf[TF_W*i +: TF_W]);
   end

   assign any_sdr = |sdr_hit;

endmodule

// File: rtl/hdr_mode_decode.sv
module hdr_mode_decode
   import hdr_path_pkg::*;
#(
   parameter int MODE_W = 4,
   parameter int CW_W   = 8
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [TF_W-1:0]   prim_tf,
   input  logic              any_sdr,
   input  logic              gamut,
   output path_en_t          en_o,
   output logic [CW_W-1:0]   cw_o,
   output logic              reject
);

   localparam logic [MODE_W-1:0] LAST_MODE = MODE_W'(M_SDR_HLG);
   localparam logic [MODE_W-1:0] LAST_HDR  = MODE_W'(M_HDR10_SDR);

   logic hdr_grp, sdr_out, bypass;

   always_comb begin
      hdr_grp = (mode <= LAST_HDR);
      bypass  = (mode == MODE_W'(M_BYPASS));
      sdr_out = hdr_grp && mode[0];
      reject  = (mode > LAST_MODE) || (hdr_grp && !tf_is_hdr(prim_tf));

      en_o.hdr_en     = hdr_grp;
      en_o.hdr_in     = hdr_grp;
      en_o.hdr2sdr_en = sdr_out;
      en_o.hdr_out    = !sdr_out;
      en_o.sdr2hdr_en = !hdr_grp || (!sdr_out && any_sdr);

      cw_o = '0;
      if (hdr_grp) begin
         cw_o[CW_TONE] = !bypass;
         cw_o[CW_BYP]  = bypass;
         cw_o[CW_PATH +: 3] = (mode == LAST_HDR) ? 3'd1 : mode[2:0];
      end
      cw_o[CW_GAMUT] = gamut;
   end

endmodule

// File: rtl/hdr_path_ctrl.sv
module hdr_path_ctrl
   import hdr_path_pkg::*;
#(
   parameter int NUM_LAYERS = 4,
   parameter int MODE_W     = 4,
   parameter int CW_W       = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       upd_valid,
   input  logic                       meta_null,
   input  logic [MODE_W-1:0]          mode_req,
   input  logic [TF_W-1:0]            prim_tf,
   input  logic [NUM_LAYERS-1:0]      layer_active,
   input  logic [TF_W*NUM_LAYERS-1:0] layer_tf,
   input  logic                       dst_gamut,
   output logic                       hdr_en,
   output logic                       hdr_in,
   output logic                       hdr_out,
   output logic                       sdr2hdr_en,
   output logic                       hdr2sdr_en,
   output logic                       cfg_err,
   output logic [CW_W-1:0]            ctrl_word
);

   if (NUM_LAYERS < 1) begin : g_bad_layers
      $error("hdr_path_ctrl: NUM_LAYERS must be at least 1");
   end
   if (MODE_W < 4) begin : g_bad_mode
      $error("hdr_path_ctrl: MODE_W must hold codes up to 15");
   end
   if (CW_W < 7) begin : g_bad_cw
      $error("hdr_path_ctrl: CW_W must reach the gamut bit");
   end

   logic            any_sdr;
   path_en_t        dec_en, en_q;
   logic [CW_W-1:0] dec_cw, cw_q;
   logic            dec_rej, err_q;

   hdr_layer_scan #(.NUM_LAYERS(NUM_LAYERS)) i_scan (
      .layer_active (layer_active),
      .layer_tf     (layer_tf),
      .any_sdr      (any_sdr)
   );

   hdr_mode_decode #(.MODE_W(MODE_W), .CW_W(CW_W)) i_dec (
      .mode    (mode_req),
      .prim_tf (prim_tf),
      .any_sdr (any_sdr),
      .gamut   (dst_gamut),
      .en_o    (dec_en),
      .cw_o    (dec_cw),
      .reject  (dec_rej)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         cw_q  <= '0;
         err_q <= 1'b0;
      end else if (meta_null) begin
         en_q  <= '0;
         cw_q  <= '0;
         err_q <= 1'b0;
      end else if (upd_valid) begin
         if (dec_rej) begin
            err_q <= 1'b1;
         end else begin
            en_q  <= dec_en;
            cw_q  <= dec_cw;
            err_q <= 1'b0;
         end
      end
   end

   assign hdr_en     = en_q.hdr_en;
   assign hdr_in     = en_q.hdr_in;
   assign hdr_out    = en_q.hdr_out;
   assign sdr2hdr_en = en_q.sdr2hdr_en;
   assign hdr2sdr_en = en_q.hdr2sdr_en;
   assign ctrl_word  = cw_q;
   assign cfg_err    = err_q;

   AST_NULL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      meta_null |=> (en_q == '0 && cw_q == '0 && !err_q)); // R10
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!meta_null && !upd_valid) |=> ($stable(en_q) && $stable(cw_q) && $stable(err_q))); // R11
   AST_RANGE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!meta_null && upd_valid && mode_req > MODE_W'(9))
      |=> (err_q && $stable(en_q) && $stable(cw_q))); // R2
   AST_TF_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!meta_null && upd_valid && mode_req <= MODE_W'(7) && !tf_is_hdr(prim_tf))
      |=> (err_q && $stable(en_q) && $stable(cw_q))); // R3
   AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_out && hdr2sdr_en)); // R5
   AST_DOWNMAP_NEEDS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
      hdr2sdr_en |-> (hdr_en && !sdr2hdr_en)); // R5

endmodule

// File: tb/test_hdr_path_ctrl.sv
`timescale 1ns/1ps
module test_hdr_path_ctrl;

   localparam int NL = 4;

   logic clk = 1'b0;
   logic rst_n, upd_valid, meta_null, dst_gamut;
   logic [3:0] mode_req;
   logic [1:0] prim_tf;
   logic [NL-1:0] layer_active;
   logic [2*NL-1:0] layer_tf;
   logic hdr_en, hdr_in, hdr_out, sdr2hdr_en, hdr2sdr_en, cfg_err;
   logic [7:0] ctrl_word;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   hdr_path_ctrl #(.NUM_LAYERS(NL)) i_hdr_path_ctrl (
      .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .meta_null(meta_null),
      .mode_req(mode_req), .prim_tf(prim_tf), .layer_active(layer_active),
      .layer_tf(layer_tf), .dst_gamut(dst_gamut), .hdr_en(hdr_en), .hdr_in(hdr_in),
      .hdr_out(hdr_out), .sdr2hdr_en(sdr2hdr_en), .hdr2sdr_en(hdr2sdr_en),
      .cfg_err(cfg_err), .ctrl_word(ctrl_word)
   );

   // en = {hdr_en, hdr_in, hdr_out, sdr2hdr_en, hdr2sdr_en}
   typedef struct packed {
      logic [3:0] m;
      logic [1:0] pt;
      logic [3:0] act;
      logic [7:0] tf;
      logic       g;
      logic [4:0] en;
      logic [7:0] cw;
   } vec_t;

   localparam vec_t VEC [12] = '{
      {4'd0, 2'd2, 4'b0001, 8'hAA, 1'b0, 5'b11100, 8'h01},
      {4'd0, 2'd3, 4'b0011, 8'hA8, 1'b0, 5'b11110, 8'h01},
      {4'd1, 2'd2, 4'b1111, 8'h00, 1'b1, 5'b11001, 8'h49},
      {4'd2, 2'd3, 4'b0001, 8'hAA, 1'b0, 5'b11100, 8'h11},
      {4'd3, 2'd3, 4'b0001, 8'hAA, 1'b0, 5'b11001, 8'h19},
      {4'd4, 2'd2, 4'b0010, 8'hA4, 1'b0, 5'b11110, 8'h21},
      {4'd4, 2'd2, 4'b1100, 8'hA4, 1'b0, 5'b11100, 8'h21},
      {4'd5, 2'd3, 4'b0001, 8'hAA, 1'b0, 5'b11001, 8'h29},
      {4'd6, 2'd2, 4'b0001, 8'hAA, 1'b1, 5'b11100, 8'h74},
      {4'd7, 2'd2, 4'b0001, 8'hAA, 1'b0, 5'b11001, 8'h09},
      {4'd8, 2'd0, 4'b0001, 8'hAA, 1'b0, 5'b00110, 8'h00},
      {4'd9, 2'd1, 4'b0001, 8'hAA, 1'b1, 5'b00110, 8'h40}
   };

   function automatic logic [13:0] obs();
      return {cfg_err, hdr_en, hdr_in, hdr_out, sdr2hdr_en, hdr2sdr_en, ctrl_word};
   endfunction

   task automatic chk(input string req, input logic [13:0] exp);
      logic [13:0] act;
      act = obs();
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got err/en/cw=%b expected %b", req, act, exp);
      end
   endtask

   task automatic set_in(input logic [3:0] m, input logic [1:0] pt, input logic [3:0] act,
                         input logic [7:0] tf, input logic g);
      mode_req = m; prim_tf = pt; layer_active = act; layer_tf = tf; dst_gamut = g;
   endtask

   task automatic apply(input logic [3:0] m, input logic [1:0] pt, input logic [3:0] act,
                        input logic [7:0] tf, input logic g);
      @(negedge clk);
      set_in(m, pt, act, tf, g);
      upd_valid = 1'b1;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   initial begin
      #1_000_000;
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; upd_valid = 1'b0; meta_null = 1'b0;
      set_in(4'd0, 2'd0, '0, '0, 1'b0);
      repeat (3) @(negedge clk);
      chk("R1 reset", 14'b0);
      rst_n = 1'b1;

      // table walk: R4 R5 R6 R7 R8 R9
      for (int i = 0; i < 12; i++) begin
         apply(VEC[i].m, VEC[i].pt, VEC[i].act, VEC[i].tf, VEC[i].g);
         chk("R4/R5/R6/R7/R8/R9 table", {1'b0, VEC[i].en, VEC[i].cw});
      end

      // R11: inputs move, no strobe
      @(negedge clk);
      set_in(4'd1, 2'd2, 4'b1111, 8'h00, 1'b0);
      repeat (3) @(negedge clk);
      chk("R11 hold", {1'b0, 5'b00110, 8'h40});

      // R12: full replacement
      apply(4'd0, 2'd3, 4'b0011, 8'hA8, 1'b0);
      chk("R12 setup", {1'b0, 5'b11110, 8'h01});
      apply(4'd1, 2'd2, 4'b0011, 8'hA8, 1'b0);
      chk("R12 replace", {1'b0, 5'b11001, 8'h09});

      // R2: out-of-range codes
      apply(4'd10, 2'd2, 4'b0001, 8'hAA, 1'b1);
      chk("R2 code10", {1'b1, 5'b11001, 8'h09});
      apply(4'd15, 2'd3, 4'b0001, 8'hAA, 1'b0);
      chk("R2 code15", {1'b1, 5'b11001, 8'h09});

      // R3: transfer-function mismatch
      apply(4'd2, 2'd0, 4'b0001, 8'hAA, 1'b1);
      chk("R3 sdr prim", {1'b1, 5'b11001, 8'h09});
      apply(4'd5, 2'd1, 4'b0001, 8'hAA, 1'b0);
      chk("R3 code1 prim", {1'b1, 5'b11001, 8'h09});

      // R12 / R4: accepted update clears error
      apply(4'd8, 2'd0, 4'b0000, 8'h00, 1'b0);
      chk("R12 err clear", {1'b0, 5'b00110, 8'h00});

      // R12 timing: no change before the capturing edge
      @(negedge clk);
      set_in(4'd6, 2'd2, 4'b0001, 8'hAA, 1'b1);
      upd_valid = 1'b1;
      #2;
      chk("R12 before edge", {1'b0, 5'b00110, 8'h00});
      @(negedge clk);
      upd_valid = 1'b0;
      chk("R12 after edge", {1'b0, 5'b11100, 8'h74});

      // R10: null wins over strobe
      @(negedge clk);
      set_in(4'd0, 2'd2, 4'b0001, 8'hAA, 1'b1);
      upd_valid = 1'b1; meta_null = 1'b1;
      @(negedge clk);
      upd_valid = 1'b0; meta_null = 1'b0;
      chk("R10 null", 14'b0);
      apply(4'd12, 2'd2, 4'b0001, 8'hAA, 1'b0);
      chk("R2 after null", {1'b1, 5'b00000, 8'h00});
      @(negedge clk);
      meta_null = 1'b1;
      @(negedge clk);
      meta_null = 1'b0;
      chk("R10 clears err", 14'b0);

      // R1: reset mid-run
      apply(4'd6, 2'd2, 4'b0001, 8'hAA, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid reset", 14'b0);
      rst_n = 1'b1;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule